// File: doc/BRIEF.md
# Text-Mode Character Pixel Generator

This block produces the pixel colour stream for a plain character-cell text display. Every cell lasts eight pixel clocks. In that time the block reads the cell's character code from the video matrix and the cell's colour attribute from a separate colour memory. It then forms the address of the glyph byte for the current scan line and reads that byte from general RAM or from character ROM. The byte is shown one pixel per clock during the next cell period, so the stream has no gaps between cells.

The raster logic outside the block supplies the cell position and the glyph row. It reads the `cell_strobe` output to know when a new cell period begins. A few configuration inputs select the video bank, the matrix block, the glyph block, the ROM window, the column width, the background colour and the display mode. Any display mode other than plain text stops all fetching and holds the output at the background colour.

Top module: `txt_pixel_gen`

## Requirements
- R1: When the glyph comes from RAM, the glyph read address is bank*0x4000 + glyph_block*0x800 + code*8 + row. The top scan line of a glyph sits at its lowest address.
- R2: When `cfg_glyph_blk` is 3'b010 or 3'b011 and `cfg_bank[0]` is 0, the glyph read asserts `mem_rom_sel` and uses address 0xD000 + code*8 + row. Every other combination reads RAM with `mem_rom_sel` low.
- R3: When `cfg_rom_alt` is 1, the ROM glyph address becomes 0xC000 + code*8 + row. The flag has no effect on RAM reads.
- R4: `cell_strobe` is high in the first cycle of each 8-cycle cell period. A cell fetched in one period is shown in the next period, with glyph bit 7 in that period's first cycle and bit 0 in its last cycle.
- R5: A pixel whose glyph bit is 1 shows bits 3:0 of the cell's colour attribute byte. A pixel whose glyph bit is 0 shows `cfg_bg_color`.
- R6: `col_addr` equals `cell_pos` when `cfg_wide` is 1. When `cfg_wide` is 0 it equals `cell_pos` with bit 10 forced to 0, giving 1024 entries.
- R7: If `cfg_ext_color`, `cfg_bitmap` or `cfg_multi` is 1, or `cfg_ctrl_b` is nonzero, then `mem_req` and `col_req` stay low and `pix_color` equals `cfg_bg_color`. A cell fetched under such a setting shows background only when it is displayed later.
- R8: The code read and the colour read are issued in the first cycle of a period, at matrix address bank*0x4000 + ((matrix_block*0x400 + cell_pos) mod 0x4000). The glyph read is issued in the third cycle. No read is issued in any other cycle.
- R9: During reset, `pix_color` equals `cfg_bg_color` and the period counter sits at its first cycle, so `cell_strobe` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_glyph_blk | input | 3 | Selects the 2 KB glyph block within the video bank |
| cfg_matrix_blk | input | 4 | Selects the 1 KB matrix block within the video bank |
| cfg_bank | input | 2 | Video bank, 16 KB granularity |
| cfg_rom_alt | input | 1 | Moves the ROM glyph window to 0xC000 |
| cfg_wide | input | 1 | 80-column colour memory depth when set |
| cfg_ext_color | input | 1 | Extended colour mode request (disables text output) |
| cfg_bitmap | input | 1 | Bitmap mode request (disables text output) |
| cfg_multi | input | 1 | Multicolour mode request (disables text output) |
| cfg_ctrl_b | input | 8 | Secondary control byte; must be zero for text output |
| cfg_bg_color | input | 4 | Background colour |
| cell_pos | input | 11 | Cell index of the cell being fetched; sampled in the first cycle |
| cell_row | input | 3 | Glyph scan line; sampled in the first cycle |
| cell_strobe | output | 1 | High in the first cycle of each cell period |
| mem_req | output | 1 | Read request to display memory |
| mem_addr | output | 16 | Read address |
| mem_rom_sel | output | 1 | High when the read targets character ROM |
| mem_rvalid | input | 1 | Read data valid, one cycle after the request |
| mem_rdata | input | 8 | Read data |
| col_req | output | 1 | Read request to colour memory |
| col_addr | output | 11 | Colour memory index |
| col_rdata | input | 8 | Colour attribute byte, one cycle after the request |
| pix_color | output | 4 | Pixel colour |

## Verification
A phase counter that drifts would move the read strobes off their slots and make `cell_strobe` fire at the wrong spacing. Both effects are visible within a single cell period. A stale code, attribute or glyph register would not change the read pattern, but it shows up eight to sixteen cycles later as a wrong pixel sequence. For that reason, every displayed pixel is compared against a model built from the memory contents. A wrong source decision shows in the same cycle as the glyph read, through `mem_rom_sel` and the address window. Sweeping every glyph block in every bank catches an error in any of the source combinations.

// File: rtl/txt_pkg.sv
package txt_pkg;
  localparam int CODE_W      = 8;
  localparam int DATA_W      = 8;
  localparam int ROW_W       = 3;
  localparam int ADDR_W      = 16;
  localparam int BANK_W      = 2;
  localparam int GSEL_W      = 3;
  localparam int MSEL_W      = 4;
  localparam int MBLK_W      = 10;
  localparam int POS_W       = 11;
  localparam int NARROW_W    = 10;
  localparam int COLR_W      = 4;
  localparam int CTRL_W      = 8;
  localparam int SPAN_W      = ADDR_W - BANK_W;
  localparam logic [ADDR_W-1:0] ROM_BASE_STD = 16'hD000;
  localparam logic [ADDR_W-1:0] ROM_BASE_ALT = 16'hC000;

  function automatic logic text_mode_on(logic ecm, logic bmm, logic mcm,
                                        logic [CTRL_W-1:0] cb);
    return !ecm && !bmm && !mcm && (cb == '0);
  endfunction

  // glyph blocks 2 and 3 in an even bank fall on the ROM image
  function automatic logic glyph_in_rom(logic [GSEL_W-1:0] gsel,
                                        logic [BANK_W-1:0] bank);
    return (gsel[GSEL_W-1:1] == 2'b01) && !bank[0];
  endfunction

  function automatic logic [ADDR_W-1:0] glyph_ram_addr(logic [BANK_W-1:0] bank,
                                                       logic [GSEL_W-1:0] gsel,
                                                       logic [CODE_W-1:0] code,
                                                       logic [ROW_W-1:0] row);
    return {bank, gsel, code, row};
  endfunction

  function automatic logic [ADDR_W-1:0] glyph_rom_addr(logic alt,
                                                       logic [CODE_W-1:0] code,
                                                       logic [ROW_W-1:0] row);
    logic [ADDR_W-1:0] off;
    off = '0;
    off[CODE_W+ROW_W-1:0] = {code, row};
    return (alt ? ROM_BASE_ALT : ROM_BASE_STD) | off;
  endfunction

  function automatic logic [ADDR_W-1:0] matrix_addr(logic [BANK_W-1:0] bank,
                                                    logic [MSEL_W-1:0] msel,
                                                    logic [POS_W-1:0] pos);
    logic [SPAN_W-1:0] off;
    logic [SPAN_W-1:0] pos_x;
    pos_x = '0;
    pos_x[POS_W-1:0] = pos;
    off = {msel, {MBLK_W{1'b0}}} + pos_x;
    return {bank, off};
  endfunction

  function automatic logic [POS_W-1:0] colour_index(logic wide, logic [POS_W-1:0] pos);
    logic [POS_W-1:0] idx;
    idx = '0;
    idx[NARROW_W-1:0] = pos[NARROW_W-1:0];
    return wide ? pos : idx;
  endfunction
endpackage

// File: rtl/txt_fetch_seq.sv
module txt_fetch_seq #(
  parameter int CELL_PX = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic at_code,
  output logic at_code_ret,
  output logic at_glyph,
  output logic at_glyph_ret,
  output logic at_last
);
  localparam int PH_W = $clog2(CELL_PX);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CELL_PX - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else                       phase <= phase + 1'b1;
  end

  assign at_code      = (phase == PH_W'(0));
  assign at_code_ret  = (phase == PH_W'(1));
  assign at_glyph     = (phase == PH_W'(2));
  assign at_glyph_ret = (phase == PH_W'(3));
  assign at_last      = (phase == PH_LAST);
endmodule

// File: rtl/txt_addr_gen.sv
module txt_addr_gen
  import txt_pkg::*;
(
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [GSEL_W-1:0] cfg_glyph_blk,
  input  logic [MSEL_W-1:0] cfg_matrix_blk,
  input  logic              cfg_rom_alt,
  input  logic              cfg_wide,
  input  logic [POS_W-1:0]  cell_pos,
  input  logic [CODE_W-1:0] code,
  input  logic [ROW_W-1:0]  row,
  output logic [ADDR_W-1:0] mtx_addr,
  output logic [ADDR_W-1:0] glyph_addr,
  output logic              glyph_rom,
  output logic [POS_W-1:0]  col_index
);
  assign mtx_addr   = matrix_addr(cfg_bank, cfg_matrix_blk, cell_pos);
  assign glyph_rom  = glyph_in_rom(cfg_glyph_blk, cfg_bank);
  assign glyph_addr = glyph_rom ? glyph_rom_addr(cfg_rom_alt, code, row)
                                : glyph_ram_addr(cfg_bank, cfg_glyph_blk, code, row);
  assign col_index  = colour_index(cfg_wide, cell_pos);
endmodule

// File: rtl/txt_pix_shift.sv
module txt_pix_shift #(
  parameter int CELL_PX = 8,
  parameter int COLR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CELL_PX-1:0] in_bits,
  input  logic [COLR_W-1:0]  in_fg,
  input  logic               mode_on,
  input  logic [COLR_W-1:0]  bg,
  output logic               lead_bit,
  output logic [COLR_W-1:0]  pix
);
  logic [CELL_PX-1:0] sh;
  logic [COLR_W-1:0]  fg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      fg_q <= '0;
    end else if (load) begin
      sh   <= in_bits;
      fg_q <= in_fg;
    end else begin
      sh   <= {sh[CELL_PX-2:0], 1'b0};
    end
  end

  assign lead_bit = sh[CELL_PX-1];
  assign pix      = (mode_on && lead_bit) ? fg_q : bg;
endmodule

// File: rtl/txt_pixel_gen.sv
module txt_pixel_gen
  import txt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_glyph_blk,
  input  logic [3:0]        cfg_matrix_blk,
  input  logic [1:0]        cfg_bank,
  input  logic              cfg_rom_alt,
  input  logic              cfg_wide,
  input  logic              cfg_ext_color,
  input  logic              cfg_bitmap,
  input  logic              cfg_multi,
  input  logic [7:0]        cfg_ctrl_b,
  input  logic [3:0]        cfg_bg_color,
  input  logic [10:0]       cell_pos,
  input  logic [2:0]        cell_row,
  output logic              cell_strobe,
  output logic              mem_req,
  output logic [15:0]       mem_addr,
  output logic              mem_rom_sel,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              col_req,
  output logic [10:0]       col_addr,
  input  logic [7:0]        col_rdata,
  output logic [3:0]        pix_color
);
  localparam int CELL_PX = DATA_W;

  logic              at_code, at_code_ret, at_glyph, at_glyph_ret, at_last;
  logic              mode_on;
  logic [CODE_W-1:0] code_q;
  logic [ROW_W-1:0]  row_q;
  logic [DATA_W-1:0] attr_q;
  logic [DATA_W-1:0] glyph_q;
  logic              glyph_ok;
  logic [ADDR_W-1:0] mtx_addr, glyph_addr;
  logic              glyph_rom;
  logic [POS_W-1:0]  col_index;
  logic              lead_bit;

  assign mode_on = text_mode_on(cfg_ext_color, cfg_bitmap, cfg_multi, cfg_ctrl_b);

  txt_fetch_seq #(.CELL_PX(CELL_PX)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .at_code(at_code), .at_code_ret(at_code_ret),
    .at_glyph(at_glyph), .at_glyph_ret(at_glyph_ret), .at_last(at_last)
  );

  txt_addr_gen u_addr (
    .cfg_bank(cfg_bank), .cfg_glyph_blk(cfg_glyph_blk), .cfg_matrix_blk(cfg_matrix_blk),
    .cfg_rom_alt(cfg_rom_alt), .cfg_wide(cfg_wide), .cell_pos(cell_pos),
    .code(code_q), .row(row_q),
    .mtx_addr(mtx_addr), .glyph_addr(glyph_addr), .glyph_rom(glyph_rom),
    .col_index(col_index)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      row_q    <= '0;
      attr_q   <= '0;
      glyph_q  <= '0;
      glyph_ok <= 1'b0;
    end else begin
      if (at_code) row_q <= cell_row;
      if (at_code_ret && mem_rvalid) code_q <= mem_rdata;
      if (at_code_ret) attr_q <= col_rdata;
      if (at_glyph_ret) glyph_ok <= mem_rvalid && mode_on;
      if (at_glyph_ret && mem_rvalid) glyph_q <= mem_rdata;
    end
  end

  assign cell_strobe = at_code;
  assign mem_req     = mode_on && (at_code || at_glyph);
  assign mem_addr    = at_glyph ? glyph_addr : mtx_addr;
  assign mem_rom_sel = mode_on && at_glyph && glyph_rom;
  assign col_req     = mode_on && at_code;
  assign col_addr    = col_index;

  txt_pix_shift #(.CELL_PX(CELL_PX), .COLR_W(COLR_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(at_last),
    .in_bits(glyph_ok ? glyph_q : '0),
    .in_fg(attr_q[COLR_W-1:0]),
    .mode_on(mode_on),
    .bg(cfg_bg_color),
    .lead_bit(lead_bit),
    .pix(pix_color)
  );
endmodule

// File: rtl/txt_pixel_gen_chk.sv
module txt_pixel_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_on,
  input logic        at_code,
  input logic        at_glyph,
  input logic        mem_req,
  input logic        col_req,
  input logic        mem_rom_sel,
  input logic [15:0] mem_addr,
  input logic        cfg_rom_alt,
  input logic        cell_strobe,
  input logic [3:0]  pix_color,
  input logic [3:0]  cfg_bg_color
);
  // R7
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |-> (!mem_req && !col_req));

  // R7
  bg_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |-> (pix_color == cfg_bg_color));

  // R8
  req_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (at_code || at_glyph));

  // R8
  code_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && at_code) |=> !mem_req);

  // R2
  rom_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rom_sel |-> (mem_req && mem_addr[15:13] == 3'b110 && !mem_addr[11]));

  // R3
  alt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rom_sel && cfg_rom_alt) |-> (mem_addr[15:11] == 5'b11000));

  // R4
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_strobe |=> !cell_strobe);
endmodule

bind txt_pixel_gen txt_pixel_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_on(mode_on), .at_code(at_code), .at_glyph(at_glyph),
  .mem_req(mem_req), .col_req(col_req), .mem_rom_sel(mem_rom_sel), .mem_addr(mem_addr),
  .cfg_rom_alt(cfg_rom_alt), .cell_strobe(cell_strobe), .pix_color(pix_color),
  .cfg_bg_color(cfg_bg_color)
);

// File: tb/txt_pixel_gen_tb.sv
module txt_pixel_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_glyph_blk = '0;
  logic [3:0]  cfg_matrix_blk = '0;
  logic [1:0]  cfg_bank = '0;
  logic        cfg_rom_alt = 1'b0, cfg_wide = 1'b0;
  logic        cfg_ext_color = 1'b0, cfg_bitmap = 1'b0, cfg_multi = 1'b0;
  logic [7:0]  cfg_ctrl_b = '0;
  logic [3:0]  cfg_bg_color = 4'h6;
  logic [10:0] cell_pos = '0;
  logic [2:0]  cell_row = '0;
  logic        cell_strobe, mem_req, mem_rom_sel, col_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0, col_rdata = '0;
  logic [10:0] col_addr;
  logic [3:0]  pix_color;

  always #(CLK_PERIOD/2) clk = ~clk;

  txt_pixel_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_glyph_blk(cfg_glyph_blk), .cfg_matrix_blk(cfg_matrix_blk),
    .cfg_bank(cfg_bank), .cfg_rom_alt(cfg_rom_alt), .cfg_wide(cfg_wide),
    .cfg_ext_color(cfg_ext_color), .cfg_bitmap(cfg_bitmap), .cfg_multi(cfg_multi),
    .cfg_ctrl_b(cfg_ctrl_b), .cfg_bg_color(cfg_bg_color), .cell_pos(cell_pos),
    .cell_row(cell_row), .cell_strobe(cell_strobe), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rom_sel(mem_rom_sel), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .col_req(col_req), .col_addr(col_addr), .col_rdata(col_rdata), .pix_color(pix_color)
  );

  // memory contents are computed, not stored
  function automatic logic [7:0] ram_f(logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd37;
    return m ^ a[15:8] ^ 8'h5C;
  endfunction
  function automatic logic [7:0] rom_f(logic [15:0] a);
    logic [7:0] s;
    s = a[7:0] + {a[12:8], 3'b0};
    return s ^ 8'hA5;
  endfunction
  function automatic logic [7:0] col_f(logic [10:0] i);
    logic [7:0] m;
    m = i[7:0] * 8'd13;
    return m ^ {i[10:8], 5'd9};
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem_rom_sel ? rom_f(mem_addr) : ram_f(mem_addr);
    col_rdata  <= col_f(col_addr);
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    int         due;
    logic [3:0] colour;
  } exp_t;
  exp_t sb_q[$];

  // monitor: compares every displayed pixel against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
        chk(sb_q[0].due == cyc && pix_color == sb_q[0].colour, "R5",
            "pixel", pix_color, sb_q[0].colour);
        void'(sb_q.pop_front());
      end
    end
  end

  typedef struct {
    logic [2:0] gsel;
    logic [3:0] msel;
    logic [1:0] bank;
    logic       alt, wide, ecm, bmm, mcm;
    logic [7:0] cb;
    logic [3:0] bg;
  } cfg_t;

  bit         first = 1;
  int         last_strobe = -1;
  logic       prev_ok = 0;
  logic [7:0] prev_glyph = '0;
  logic [3:0] prev_fg = '0;

  task automatic do_cell(input cfg_t c, input logic [10:0] pos, input logic [2:0] row);
    logic        on, rom;
    logic [15:0] maddr, gaddr;
    logic [13:0] moff;
    logic [7:0]  code, glyph, attr;
    logic [10:0] cidx;
    do @(negedge clk); while (!cell_strobe);
    if (last_strobe >= 0)
      chk(cyc - last_strobe == 8, "R4", "strobe spacing", cyc - last_strobe, 8);
    last_strobe = cyc;
    on = !c.ecm && !c.bmm && !c.mcm && c.cb == 8'h00;
    if (!first)
      for (int j = 0; j < 8; j++) begin
        exp_t e;
        e.due    = cyc + j;
        e.colour = (on && prev_ok && prev_glyph[7-j]) ? prev_fg : c.bg;
        sb_q.push_back(e);
      end
    cfg_glyph_blk = c.gsel; cfg_matrix_blk = c.msel; cfg_bank = c.bank;
    cfg_rom_alt = c.alt; cfg_wide = c.wide; cfg_ext_color = c.ecm;
    cfg_bitmap = c.bmm; cfg_multi = c.mcm; cfg_ctrl_b = c.cb; cfg_bg_color = c.bg;
    cell_pos = pos; cell_row = row;
    moff  = 14'(c.msel * 1024 + pos);
    maddr = {c.bank, moff};
    code  = ram_f(maddr);
    cidx  = c.wide ? pos : {1'b0, pos[9:0]};
    attr  = col_f(cidx);
    rom   = (c.gsel == 3'd2 || c.gsel == 3'd3) && c.bank[0] == 1'b0;
    gaddr = rom ? ((c.alt ? 16'hC000 : 16'hD000) + 16'(code) * 16'd8 + 16'(row))
                : (16'(c.bank) * 16'h4000 + 16'(c.gsel) * 16'h0800 + 16'(code) * 16'd8 + 16'(row));
    glyph = rom ? rom_f(gaddr) : ram_f(gaddr);
    #1;
    chk(mem_req == on, on ? "R8" : "R7", "code req", mem_req, on);
    chk(col_req == on, on ? "R8" : "R7", "colour req", col_req, on);
    if (on) begin
      chk(mem_addr == maddr, "R8", "matrix addr", mem_addr, maddr);
      chk(mem_rom_sel == 1'b0, "R8", "code rom_sel", mem_rom_sel, 0);
      chk(col_addr == cidx, "R6", "colour index", col_addr, cidx);
    end
    @(negedge clk); #1;
    chk(mem_req == 1'b0 && col_req == 1'b0, "R8", "idle slot", mem_req, 0);
    @(negedge clk); #1;
    chk(mem_req == on, on ? "R8" : "R7", "glyph req", mem_req, on);
    if (on) begin
      chk(mem_rom_sel == rom, rom ? "R2" : "R1", "glyph source", mem_rom_sel, rom);
      chk(mem_addr == gaddr, rom ? (c.alt ? "R3" : "R2") : "R1", "glyph addr", mem_addr, gaddr);
    end else begin
      chk(mem_rom_sel == 1'b0, "R7", "rom_sel idle", mem_rom_sel, 0);
    end
    prev_ok    = on;
    prev_glyph = glyph;
    prev_fg    = attr[3:0];
    first      = 0;
  endtask

  function automatic cfg_t base_cfg();
    cfg_t c;
    c.gsel = 3'd1; c.msel = 4'd1; c.bank = 2'd0; c.alt = 1'b0; c.wide = 1'b0;
    c.ecm = 1'b0; c.bmm = 1'b0; c.mcm = 1'b0; c.cb = 8'h00; c.bg = 4'h6;
    return c;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cfg_t c;
    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(pix_color == cfg_bg_color, "R9", "reset pixel", pix_color, cfg_bg_color);
    chk(cell_strobe == 1'b1, "R9", "reset phase", cell_strobe, 1);
    rst_n = 1'b1;

    // R1 R2 R3: every glyph block in every bank
    for (int b = 0; b < 4; b++)
      for (int g = 0; g < 8; g++) begin
        c = base_cfg();
        c.bank = 2'(b); c.gsel = 3'(g); c.alt = b[1]; c.msel = 4'(g + b);
        c.bg = 4'(g + 3);
        do_cell(c, 11'(b * 97 + g * 13), 3'(b + g));
      end

    // R3: alternate window does not touch RAM reads
    c = base_cfg(); c.alt = 1'b1; c.gsel = 3'd5;
    do_cell(c, 11'd40, 3'd7);
    c.gsel = 3'd3; c.bank = 2'd2;
    do_cell(c, 11'd41, 3'd0);

    // R6: colour index width
    c = base_cfg(); c.wide = 1'b0;
    do_cell(c, 11'd1500, 3'd2);
    c.wide = 1'b1;
    do_cell(c, 11'd1500, 3'd2);
    do_cell(c, 11'd1023, 3'd5);
    do_cell(c, 11'd1024, 3'd5);
    c.wide = 1'b0; c.msel = 4'd15;
    do_cell(c, 11'd2047, 3'd1);

    // R7: each disabling setting
    c = base_cfg(); c.ecm = 1'b1; c.bg = 4'h9;
    do_cell(c, 11'd7, 3'd3);
    c = base_cfg(); c.bmm = 1'b1; c.bg = 4'hA;
    do_cell(c, 11'd8, 3'd3);
    c = base_cfg(); c.mcm = 1'b1; c.bg = 4'hB;
    do_cell(c, 11'd9, 3'd3);
    c = base_cfg(); c.cb = 8'h01;
    do_cell(c, 11'd10, 3'd4);
    c = base_cfg(); c.cb = 8'h80;
    do_cell(c, 11'd11, 3'd4);
    c = base_cfg();
    do_cell(c, 11'd12, 3'd4);
    do_cell(c, 11'd13, 3'd6);

    // R4 R5: flush the last fetched cell to the display
    c = base_cfg(); c.bg = 4'h2;
    do_cell(c, 11'd14, 3'd0);
    repeat (12) @(negedge clk);
    chk(sb_q.size() == 0, "R4", "scoreboard drained", sb_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule